// File: doc/BRIEF.md
# Ring Indicator Pulse-Train Filter

This block conditions three active-low ring-indicate inputs. Each channel has its own mode bit in a small select register. With the bit clear, the channel is a bypass: the input is synchronized and passed to the output, and a downstream falling-edge detector treats any high-to-low transition as a ring event. With the bit set, the channel passes only a genuine ringing cadence. The falling edges must repeat at least as fast as a programmable period limit, by default 67 ticks, which is about 15 Hz on a 1 kHz timebase. They must keep that rate for a qualification window, by default 200 ticks. Only then does the output go low, and the leading falling edge of that low pulse is the ring trigger.

Once a train has qualified, the output stays low while edges keep arriving within the period limit. It is released when the gap since the last edge exceeds the limit, but never before a minimum low time has elapsed, which is also 200 ticks by default. Any gap longer than the period limit before qualification throws away the time already accumulated, so the next edge starts a fresh qualification window. Time is measured in pulses of a slow `tick` input, which the surrounding logic supplies from a 1 kHz divider.

Top module: `ring_train_filter`

## Requirements
- R1: After reset the select register reads 0x00, so every channel is in bypass.
- R2: Select bits 2:0 are written from `regWrData[2:0]` when `regWrEn` is high. Bits 7:3 always read 0, and writing ones to them has no effect.
- R3: In bypass, `ringOutN[n]` equals `ringInN[n]` delayed by exactly two clock cycles, through a two-flop synchronizer.
- R4: Select bit n affects channel n only. A bypassed channel follows its input while other channels filter.
- R5: In filter mode, the output goes low once falling edges spaced at most LIMIT ticks apart (spacing 67 qualifies) have continued for QUAL ticks since the first edge. This happens at tick 200 after the first edge. Before then the output stays high.
- R6: In filter mode, a spacing of LIMIT+1 ticks or more between falling edges (68 at defaults) never qualifies. Such a gap restarts the qualification window from the next edge.
- R7: A qualified output stays low while edges keep coming within LIMIT ticks. It returns high LIMIT+1 ticks after the last edge, once the minimum low time has passed.
- R8: A qualified output stays low for at least MINLOW ticks (200) after it falls, even if the edges stop earlier.
- R9: Clearing a channel's select bit while its output is held low returns that output at once to following the synchronized input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timebase pulse (1 kHz nominal) |
| regWrEn | input | 1 | Write strobe for the select register |
| regWrData | input | 8 | Write data; bits 2:0 are the channel filter enables |
| regRdData | output | 8 | Select register read value; bits 7:3 are zero |
| ringInN | input | 3 | Raw active-low ring inputs, bit n is channel n |
| ringOutN | output | 3 | Conditioned active-low ring outputs |

## Verification
A gap counter that saturates at the wrong value, or is compared with an off-by-one limit, shows up as a spacing of 67 failing or 68 passing. The first wrong output level appears at tick 200 of the train. A run or low-time counter that is not cleared at the right moment moves the falling or rising output edge away from tick 200, or away from the end of the minimum low time. A bench sample placed 10 ticks on either side of those points catches the error within that window. A channel whose state machine does not drop back to idle when its select bit is cleared keeps its output low against a high input. That shows up within the few cycles after the register write.

// File: rtl/ringPkg.sv
package ringPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } chState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrGap;
    logic clrRun;
    logic clrLow;
  } ctrlStrb_t;

  // Status flags from datapath to control
  typedef struct packed {
    logic fall;
    logic gapOver;
    logic runDone;
    logic lowDone;
  } dpFlags_t;

endpackage

// File: rtl/ring_chan_dp.sv
module ring_chan_dp
  import ringPkg::*;
#(
  parameter int LIMIT  = 67,
  parameter int QUAL   = 200,
  parameter int MINLOW = 200
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rawInN,
  input  ctrlStrb_t strb,
  output dpFlags_t  flags,
  output logic      syncLevel
);

  localparam int GAP_W = $clog2(LIMIT + 2);
  localparam int RUN_W = $clog2(QUAL + 1);
  localparam int LOW_W = $clog2(MINLOW + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(LIMIT);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(QUAL);
  localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(MINLOW);

  logic sync1, sync2, prevQ;
  logic [GAP_W-1:0] gapCnt;
  logic [RUN_W-1:0] runCnt;
  logic [LOW_W-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      prevQ <= 1'b1;
    end else begin
      sync1 <= rawInN;
      sync2 <= sync1;
      prevQ <= sync2;
    end
  end

  // Ticks since last falling edge, saturating one past the limit
  always_ff @(posedge clk) begin
    if (rst || strb.clrGap) gapCnt <= '0;
    else if (tick && gapCnt <= GAP_LIM) gapCnt <= gapCnt + 1'b1;
  end

  // Ticks since the train started
  always_ff @(posedge clk) begin
    if (rst || strb.clrRun) runCnt <= '0;
    else if (tick && runCnt < RUN_LIM) runCnt <= runCnt + 1'b1;
  end

  // Ticks since the output went low
  always_ff @(posedge clk) begin
    if (rst || strb.clrLow) lowCnt <= '0;
    else if (tick && lowCnt < LOW_LIM) lowCnt <= lowCnt + 1'b1;
  end

  assign syncLevel     = sync2;
  assign flags.fall    = prevQ & ~sync2;
  assign flags.gapOver = gapCnt > GAP_LIM;
  assign flags.runDone = runCnt >= RUN_LIM;
  assign flags.lowDone = lowCnt >= LOW_LIM;

  // R3: the synchronized level lags the raw pin by two cycles
  p_sync_delay_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (syncLevel == $past(rawInN, 2)));

endmodule

// File: rtl/ring_chan_ctrl.sv
module ring_chan_ctrl
  import ringPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      selEn,
  input  dpFlags_t  flags,
  output ctrlStrb_t strb,
  output logic      lowActive
);

  chState_e st, stNext;

  always_comb begin
    stNext = st;
    strb   = '0;
    if (!selEn) begin
      stNext = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (flags.fall) begin
            strb.clrGap = 1'b1;
            strb.clrRun = 1'b1;
            stNext      = ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (flags.fall) begin
            strb.clrGap = 1'b1;
            if (flags.gapOver) begin
              strb.clrRun = 1'b1;
            end else if (flags.runDone) begin
              strb.clrLow = 1'b1;
              stNext      = ST_ACTIVE;
            end
          end else if (flags.gapOver) begin
            stNext = ST_IDLE;
          end else if (flags.runDone) begin
            strb.clrLow = 1'b1;
            stNext      = ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (flags.fall) strb.clrGap = 1'b1;
          else if (flags.gapOver && flags.lowDone) stNext = ST_IDLE;
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= stNext;
  end

  assign lowActive = (st == ST_ACTIVE);

  // R9: a bypassed channel is back in idle one cycle later
  p_bypass_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !selEn |=> (st == ST_IDLE));

  // R5: entering the low state needs a full qualification window
  p_qual_run_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACTIVE && $past(st) == ST_ARMED) |-> $past(flags.runDone));

  // R6: a broken spacing before qualification drops the train
  p_gap_break_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_ARMED && $past(flags.gapOver) && !$past(flags.fall)
     && $past(selEn)) |-> (st == ST_IDLE));

  // R8: release only after the minimum low time and a lost train
  p_min_low_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_ACTIVE && st != ST_ACTIVE && $past(selEn))
      |-> ($past(flags.lowDone) && $past(flags.gapOver)));

endmodule

// File: rtl/ring_train_filter.sv
module ring_train_filter
  import ringPkg::*;
#(
  parameter int NCH    = 3,
  parameter int REG_W  = 8,
  parameter int LIMIT  = 67,
  parameter int QUAL   = 200,
  parameter int MINLOW = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic [NCH-1:0]   ringInN,
  output logic [NCH-1:0]   ringOutN
);

  localparam int RSVD_W = REG_W - NCH;

  logic [NCH-1:0] selReg;
  logic           unusedRsvd;

  always_ff @(posedge clk) begin
    if (rst)          selReg <= '0;
    else if (regWrEn) selReg <= regWrData[NCH-1:0];
  end

  assign unusedRsvd = ^regWrData[REG_W-1:NCH];
  assign regRdData  = {{RSVD_W{1'b0}}, selReg};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    ctrlStrb_t strb;
    dpFlags_t  flags;
    logic      syncLevel;
    logic      lowActive;

    ring_chan_dp #(
      .LIMIT (LIMIT),
      .QUAL  (QUAL),
      .MINLOW(MINLOW)
    ) u_dp (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .rawInN   (ringInN[ch]),
      .strb     (strb),
      .flags    (flags),
      .syncLevel(syncLevel)
    );

    ring_chan_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .selEn    (selReg[ch]),
      .flags    (flags),
      .strb     (strb),
      .lowActive(lowActive)
    );

    assign ringOutN[ch] = selReg[ch] ? ~lowActive : syncLevel;
  end

  // R2: a write loads the enable bits on the next cycle
  p_sel_write_r2: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> (regRdData[NCH-1:0] == $past(regWrData[NCH-1:0])));

endmodule

// File: tb/ring_train_filter_tb.sv
module ring_train_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 13;
  // period, falls, sample tick, expected filtered level
  localparam int VEC[ROWS][4] = '{
    '{50,  5, 150, 1},
    '{50,  5, 210, 0},
    '{50,  5, 390, 0},
    '{50,  5, 410, 1},
    '{50, 13, 600, 0},
    '{50, 13, 660, 0},
    '{50, 13, 680, 1},
    '{80,  8, 300, 1},
    '{80,  8, 500, 1},
    '{10, 30, 205, 0},
    '{10, 30, 410, 1},
    '{67,  5, 210, 0},
    '{68,  6, 300, 1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [2:0] ringInN = 3'b111;
  logic [2:0] ringOutN;

  int checks = 0;
  int errors = 0;

  ring_train_filter u_dut (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .ringInN  (ringInN),
    .ringOutN (ringOutN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic string rowTag(int r);
    case (r)
      0, 1, 9, 11: return "R5";
      2, 3, 10:    return "R8";
      4, 5, 6:     return "R7";
      default:     return "R6";
    endcase
  endfunction

  function automatic logic waveLvl(int per, int n, int t);
    if (t < per * n) return ((t % per) < (per / 2)) ? 1'b0 : 1'b1;
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    ringInN = 3'b111;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeSel(logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic stepTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state
    chk("R1 reset select", regRdData, 8'h00);
    chk("R1 reset outputs", {5'b0, ringOutN}, 8'h07);

    // R3: two-cycle bypass latency
    @(negedge clk);
    ringInN = 3'b010;
    @(negedge clk);
    chk("R3 bypass one cycle", {5'b0, ringOutN}, 8'h07);
    @(negedge clk);
    chk("R3 bypass two cycles", {5'b0, ringOutN}, 8'h02);
    ringInN = 3'b111;
    repeat (3) @(negedge clk);

    // R2: writable and reserved bits
    writeSel(8'hFF);
    chk("R2 write ones", regRdData, 8'h07);
    writeSel(8'hA5);
    chk("R2 reserved ignored", regRdData, 8'h05);

    // Table walk: channels 0 and 1 filter, channel 2 bypass
    for (int r = 0; r < ROWS; r++) begin
      doReset();
      writeSel(8'h03);
      for (int t = 0; t <= VEC[r][2]; t++) begin
        ringInN = {3{waveLvl(VEC[r][0], VEC[r][1], t)}};
        stepTick();
        if (t == VEC[r][2]) begin
          chk(rowTag(r), {7'b0, ringOutN[0]}, 8'(VEC[r][3]));
          chk(rowTag(r), {7'b0, ringOutN[1]}, 8'(VEC[r][3]));
          chk("R4 bypass channel", {7'b0, ringOutN[2]}, {7'b0, ringInN[2]});
        end
      end
    end

    // R6: gap in the train restarts qualification
    doReset();
    writeSel(8'h01);
    for (int t = 0; t <= 410; t++) begin
      if (t < 150) ringInN[0] = ((t % 50) < 25) ? 1'b0 : 1'b1;
      else if (t >= 200 && t < 500) ringInN[0] = (((t - 200) % 50) < 25) ? 1'b0 : 1'b1;
      else ringInN[0] = 1'b1;
      stepTick();
      if (t == 390) chk("R6 gap restart high", {7'b0, ringOutN[0]}, 8'h01);
      if (t == 410) chk("R6 gap restart low", {7'b0, ringOutN[0]}, 8'h00);
    end

    // R9: clearing the enable while active restores bypass
    doReset();
    writeSel(8'h01);
    for (int t = 0; t <= 250; t++) begin
      ringInN[0] = waveLvl(50, 20, t);
      stepTick();
    end
    chk("R9 active before clear", {7'b0, ringOutN[0]}, 8'h00);
    writeSel(8'h00);
    for (int t = 251; t <= 280; t++) begin
      ringInN[0] = waveLvl(50, 20, t);
      stepTick();
    end
    chk("R9 bypass after clear", {7'b0, ringOutN[0]}, 8'h01);
    @(negedge clk);
    ringInN[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 bypass follows low", {7'b0, ringOutN[0]}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule